// File: doc/BRIEF.md
# Disk Command Execution Sequencer

This block carries out one disk command at a time for a single attached drive. The command arrives as a six-byte control block, already gathered by the register side. The sequencer decodes it and then works through the command. For reads and writes it can seek first, and it checks each sector address against the drive geometry. It waits a fixed settle period for each sector and then hands the sector address to the data mover through a request/done handshake. After the sector it steps to the next sector, head and cylinder. It stops when the sector count is used up or when an error ends the command.

Verify variants run the same per-sector loop but never raise a transfer request. Seek, park and recalibrate change the current cylinder without any data phase. Opcodes the block does not execute are rejected at once with an invalid-command status. At the end of every command a single-cycle `done` pulse is raised. At that moment the error flags, the interrupt status bits and the progress syndrome are valid, and they hold until the next command is accepted.

Control block layout (byte k at `cmd_ccb[8k+7:8k]`): byte 0 holds the opcode in bits 7:4, park in bit 0 and auto-seek in bit 2. Byte 1 holds cylinder bits 9:8 in bits 1:0 and the head in bits 7:4. Byte 2 is cylinder bits 7:0, byte 3 is the first sector and byte 5 is the sector count. Opcodes: 1 read, 2 read-verify, 3 read-extended, 5 read-ID, 8 recalibrate, 9 write, A write-verify, E seek.

Top module: `disk_cmd_seq`

## Requirements
- R1: After reset the block is idle: `cmd_ready`=1, `busy`=0, `done`=0, `xfer_req`=0, `err_flags`=0, `syndrome`=0 and `cur_cyl`=0.
- R2: A read (opcode 1) requests `count` sectors with `xfer_write`=0. The first is at the command sector. Each next sector is one higher; past `drive_spt` the sector goes back to 1 with the next head, and past the last head the head goes to 0 with the next cylinder. On success `syndrome`=0xD4 and `err_flags`=0.
- R3: A write (opcode 9) follows the same sector order as a read with `xfer_write`=1, and also ends with `syndrome`=0xD4.
- R4: Read-verify (2) and write-verify (A) never raise `xfer_req`. Each sector still takes exactly SECTOR_DELAY+2 cycles, and success ends with 0xD4.
- R5: With auto-seek (byte 0 bit 2) set, `cur_cyl` takes the command cylinder before the first sector. A cylinder at or above `drive_cyls` sets cylinder-error (`err_flags` bit 1) and ends with no transfer.
- R6: With auto-seek clear, a command cylinder that differs from `cur_cyl` sets wrong-cylinder (`err_flags` bit 2) and ends with no transfer.
- R7: A head at or above `drive_heads` sets cylinder-error (bit 1). A sector above `drive_spt` sets mark-not-found (bit 3). Either one ends the command with no transfer.
- R8: Seek (E) moves `cur_cyl` to the command cylinder, or to `drive_cyls`-1 when park (byte 0 bit 0) is set, and raises `seek_end`. An out-of-range target sets cylinder-error, leaves `seek_end` low and leaves `cur_cyl` unchanged.
- R9: Recalibrate (8) sets `cur_cyl` to 0. With no drive it sets not-ready (bit 0) and `term_err` instead.
- R10: Read-extended (3), read-ID (5), the format opcodes and any undefined opcode set invalid-command (bit 4). With no drive, read-extended and read-ID report not-ready alone.
- R11: A read, write or verify issued with `drive_present`=0 sets not-ready (bit 0) and raises no transfer request.
- R12: `xfer_err` during a transfer sets `equip_check` and `need_reset`. The command ends on the next cycle with `syndrome`=0, and no later sector is requested.
- R13: `done` is high for exactly one cycle per command. `busy` rises the cycle after a command is accepted and falls after `done`.
- R14: A multi-sector transfer that would step past the last cylinder sets cylinder-error and ends before requesting that sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Control block offered |
| cmd_ccb | input | 48 | Six-byte control block, byte 0 in bits 7:0 |
| cmd_ready | output | 1 | Sequencer idle, accepts a control block |
| drive_present | input | 1 | Drive attached |
| drive_cyls | input | 10 | Drive cylinder count |
| drive_heads | input | 5 | Drive head count |
| drive_spt | input | 8 | Sectors per track |
| xfer_req | output | 1 | Sector transfer request, held until done or error |
| xfer_write | output | 1 | 1 = host to disk |
| xfer_cyl | output | 10 | Sector cylinder |
| xfer_head | output | 4 | Sector head |
| xfer_sector | output | 8 | Sector number |
| xfer_done | input | 1 | Sector moved |
| xfer_err | input | 1 | Data mover underrun or overrun |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_flags | output | 5 | {invalid, mark-not-found, wrong-cyl, cyl-error, not-ready} |
| equip_check | output | 1 | Equipment-check interrupt status |
| term_err | output | 1 | Termination-error interrupt status |
| need_reset | output | 1 | Need-reset sense bit |
| seek_end | output | 1 | Seek completed |
| syndrome | output | 8 | Progress syndrome, 0xD4 on transfer success |
| cur_cyl | output | 10 | Current head cylinder |

## Verification
On every cycle the assertions check the following: `done` lasts one cycle, an accepted command raises `busy`, and the sector address stays stable while a request waits. They also check that verify commands never raise a request, that a 0xD4 syndrome comes with clean flags, that a data-mover error ends the command on the next cycle, and that a successful seek lands inside the drive. Only the bench scenarios can show that sector order, head wrap and cylinder wrap are correct, and that the per-sector timing is right. The same holds for the choice of error flag for each bad address or opcode, and for the final cylinder after seek, park and recalibrate.

// File: rtl/dseq_pkg.sv
`timescale 1ns/1ps
package dseq_pkg;
   localparam int CYL_W    = 10;
   localparam int HEAD_W   = 4;
   localparam int SEC_W    = 8;
   localparam int CNT_W    = 8;
   localparam int CCB_BYTES = 6;
   localparam int CCB_W    = 8 * CCB_BYTES;

   localparam logic [3:0] OP_READ  = 4'h1;
   localparam logic [3:0] OP_RVER  = 4'h2;
   localparam logic [3:0] OP_REXT  = 4'h3;
   localparam logic [3:0] OP_RID   = 4'h5;
   localparam logic [3:0] OP_RECAL = 4'h8;
   localparam logic [3:0] OP_WRITE = 4'h9;
   localparam logic [3:0] OP_WVER  = 4'hA;
   localparam logic [3:0] OP_SEEK  = 4'hE;

   localparam int F_NRDY = 0;
   localparam int F_CYL  = 1;
   localparam int F_WCYL = 2;
   localparam int F_MARK = 3;
   localparam int F_INV  = 4;
   localparam int FLAG_N = 5;

   localparam logic [7:0] SYND_OK = 8'hD4;

   typedef struct packed {
      logic [3:0]        opcode;
      logic              park;
      logic              auto_seek;
      logic [CYL_W-1:0]  cyl;
      logic [HEAD_W-1:0] head;
      logic [SEC_W-1:0]  sector;
      logic [CNT_W-1:0]  count;
   } cmd_t;

   typedef enum logic [2:0] {
      S_IDLE, S_DECODE, S_CHECK, S_WAIT, S_XFER, S_STEP, S_FINISH
   } seq_state_e;
endpackage

// File: rtl/dseq_ccb_decode.sv
`timescale 1ns/1ps
module dseq_ccb_decode
   import dseq_pkg::*;
(
   input  logic [CCB_W-1:0] ccb,
   output cmd_t             cmd
);
   logic unused_ccb_bits;
   assign unused_ccb_bits = ^{ccb[1], ccb[3], ccb[11:10], ccb[39:32]};

   always_comb begin
      cmd.opcode    = ccb[7:4];
      cmd.park      = ccb[0];
      cmd.auto_seek = ccb[2];
      cmd.cyl       = {ccb[9:8], ccb[23:16]};
      cmd.head      = ccb[15:12];
      cmd.sector    = ccb[31:24];
      cmd.count     = ccb[47:40];
   end
endmodule

// File: rtl/dseq_delay.sv
`timescale 1ns/1ps
module dseq_delay #(
   parameter int DELAY = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expired
);
   localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;

   generate
      if (DELAY < 1) begin : g_bad_delay
         $error("dseq_delay: DELAY must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= CW'(DELAY - 1);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // R4
   settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (DELAY > 1)) |=> !expired);
endmodule

// File: rtl/dseq_chs_step.sv
`timescale 1ns/1ps
module dseq_chs_step
   import dseq_pkg::*;
(
   input  logic [CYL_W-1:0]  cyl,
   input  logic [HEAD_W-1:0] head,
   input  logic [SEC_W-1:0]  sec,
   input  logic [CYL_W-1:0]  cyls,
   input  logic [HEAD_W:0]   heads,
   input  logic [SEC_W-1:0]  spt,
   output logic [CYL_W-1:0]  nxt_cyl,
   output logic [HEAD_W-1:0] nxt_head,
   output logic [SEC_W-1:0]  nxt_sec,
   output logic              past_end
);
   logic [HEAD_W:0] head_inc;
   logic [CYL_W:0]  cyl_inc;

   assign head_inc = {1'b0, head} + (HEAD_W+1)'(1);
   assign cyl_inc  = {1'b0, cyl} + (CYL_W+1)'(1);

   always_comb begin
      nxt_cyl  = cyl;
      nxt_head = head;
      nxt_sec  = sec + 1'b1;
      past_end = 1'b0;
      if (sec >= spt) begin
         nxt_sec = SEC_W'(1);
         if (head_inc >= heads) begin
            nxt_head = '0;
            nxt_cyl  = cyl_inc[CYL_W-1:0];
            past_end = (cyl_inc >= {1'b0, cyls});
         end else begin
            nxt_head = head_inc[HEAD_W-1:0];
         end
      end
   end
endmodule

// File: rtl/disk_cmd_seq.sv
`timescale 1ns/1ps
module disk_cmd_seq
   import dseq_pkg::*;
#(
   parameter int SECTOR_DELAY = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [CCB_W-1:0]  cmd_ccb,
   output logic              cmd_ready,
   input  logic              drive_present,
   input  logic [CYL_W-1:0]  drive_cyls,
   input  logic [HEAD_W:0]   drive_heads,
   input  logic [SEC_W-1:0]  drive_spt,
   output logic              xfer_req,
   output logic              xfer_write,
   output logic [CYL_W-1:0]  xfer_cyl,
   output logic [HEAD_W-1:0] xfer_head,
   output logic [SEC_W-1:0]  xfer_sector,
   input  logic              xfer_done,
   input  logic              xfer_err,
   output logic              busy,
   output logic              done,
   output logic [FLAG_N-1:0] err_flags,
   output logic              equip_check,
   output logic              term_err,
   output logic              need_reset,
   output logic              seek_end,
   output logic [7:0]        syndrome,
   output logic [CYL_W-1:0]  cur_cyl
);
   generate
      if (SECTOR_DELAY < 1) begin : g_bad_param
         $error("disk_cmd_seq: SECTOR_DELAY must be at least 1");
      end
   endgenerate

   seq_state_e state;
   cmd_t       dec, cmd_q;

   logic [CYL_W-1:0]  a_cyl, cur_cyl_q, n_cyl, seek_tgt;
   logic [HEAD_W-1:0] a_head, n_head;
   logic [SEC_W-1:0]  a_sec, n_sec;
   logic [CNT_W-1:0]  cnt_q;
   logic              n_past;
   logic [FLAG_N-1:0] flags_q;
   logic              equip_q, term_q, nrst_q, seek_end_q;
   logic [7:0]        synd_q;
   logic              is_data, is_verify, is_write, addr_ok, t_start, t_exp;

   dseq_ccb_decode u_dec (.ccb(cmd_ccb), .cmd(dec));

   dseq_delay #(.DELAY(SECTOR_DELAY)) u_dly (
      .clk(clk), .rst_n(rst_n), .start(t_start), .expired(t_exp));

   dseq_chs_step u_step (
      .cyl(a_cyl), .head(a_head), .sec(a_sec),
      .cyls(drive_cyls), .heads(drive_heads), .spt(drive_spt),
      .nxt_cyl(n_cyl), .nxt_head(n_head), .nxt_sec(n_sec), .past_end(n_past));

   always_comb begin
      is_verify = (cmd_q.opcode == OP_RVER) || (cmd_q.opcode == OP_WVER);
      is_write  = (cmd_q.opcode == OP_WRITE) || (cmd_q.opcode == OP_WVER);
      is_data   = is_verify || (cmd_q.opcode == OP_READ) || (cmd_q.opcode == OP_WRITE);
      addr_ok   = ({1'b0, a_head} < drive_heads) && (a_sec <= drive_spt);
      t_start   = (state == S_CHECK) && addr_ok;
      seek_tgt  = cmd_q.park ? (drive_cyls - 1'b1) : cmd_q.cyl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         cmd_q      <= '0;
         a_cyl      <= '0;
         a_head     <= '0;
         a_sec      <= '0;
         cnt_q      <= '0;
         cur_cyl_q  <= '0;
         flags_q    <= '0;
         equip_q    <= 1'b0;
         term_q     <= 1'b0;
         nrst_q     <= 1'b0;
         seek_end_q <= 1'b0;
         synd_q     <= '0;
      end else begin
         unique case (state)
            S_IDLE: if (cmd_valid) begin
               cmd_q      <= dec;
               flags_q    <= '0;
               equip_q    <= 1'b0;
               term_q     <= 1'b0;
               nrst_q     <= 1'b0;
               seek_end_q <= 1'b0;
               synd_q     <= '0;
               state      <= S_DECODE;
            end
            S_DECODE: begin
               state <= S_FINISH;
               a_head <= cmd_q.head;
               a_sec  <= cmd_q.sector;
               cnt_q  <= cmd_q.count;
               if (is_data) begin
                  if (!drive_present)
                     flags_q[F_NRDY] <= 1'b1;
                  else if (cmd_q.auto_seek) begin
                     if (cmd_q.cyl >= drive_cyls)
                        flags_q[F_CYL] <= 1'b1;
                     else begin
                        cur_cyl_q <= cmd_q.cyl;
                        a_cyl     <= cmd_q.cyl;
                        state     <= S_CHECK;
                     end
                  end else if (cmd_q.cyl != cur_cyl_q)
                     flags_q[F_WCYL] <= 1'b1;
                  else begin
                     a_cyl <= cur_cyl_q;
                     state <= S_CHECK;
                  end
               end else begin
                  case (cmd_q.opcode)
                     OP_REXT, OP_RID: begin
                        if (!drive_present) flags_q[F_NRDY] <= 1'b1;
                        else                flags_q[F_INV]  <= 1'b1;
                     end
                     OP_RECAL: begin
                        if (drive_present) cur_cyl_q <= '0;
                        else begin
                           flags_q[F_NRDY] <= 1'b1;
                           term_q          <= 1'b1;
                        end
                     end
                     OP_SEEK: begin
                        if (!drive_present)
                           flags_q[F_NRDY] <= 1'b1;
                        else if (seek_tgt >= drive_cyls)
                           flags_q[F_CYL] <= 1'b1;
                        else begin
                           cur_cyl_q  <= seek_tgt;
                           seek_end_q <= 1'b1;
                        end
                     end
                     default: flags_q[F_INV] <= 1'b1;
                  endcase
               end
            end
            S_CHECK: begin
               if ({1'b0, a_head} >= drive_heads) begin
                  flags_q[F_CYL] <= 1'b1;
                  state          <= S_FINISH;
               end else if (a_sec > drive_spt) begin
                  flags_q[F_MARK] <= 1'b1;
                  state           <= S_FINISH;
               end else
                  state <= S_WAIT;
            end
            S_WAIT: if (t_exp) state <= is_verify ? S_STEP : S_XFER;
            S_XFER: begin
               if (xfer_err) begin
                  equip_q <= 1'b1;
                  nrst_q  <= 1'b1;
                  state   <= S_FINISH;
               end else if (xfer_done)
                  state <= S_STEP;
            end
            S_STEP: begin
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == CNT_W'(1)) begin
                  synd_q <= SYND_OK;
                  state  <= S_FINISH;
               end else if (n_past) begin
                  flags_q[F_CYL] <= 1'b1;
                  state          <= S_FINISH;
               end else begin
                  a_cyl     <= n_cyl;
                  a_head    <= n_head;
                  a_sec     <= n_sec;
                  cur_cyl_q <= n_cyl;
                  state     <= S_CHECK;
               end
            end
            S_FINISH: state <= S_IDLE;
            default:  state <= S_IDLE;
         endcase
      end
   end

   assign cmd_ready   = (state == S_IDLE);
   assign busy        = (state != S_IDLE);
   assign done        = (state == S_FINISH);
   assign xfer_req    = (state == S_XFER);
   assign xfer_write  = is_write;
   assign xfer_cyl    = a_cyl;
   assign xfer_head   = a_head;
   assign xfer_sector = a_sec;
   assign err_flags   = flags_q;
   assign equip_check = equip_q;
   assign term_err    = term_q;
   assign need_reset  = nrst_q;
   assign seek_end    = seek_end_q;
   assign syndrome    = synd_q;
   assign cur_cyl     = cur_cyl_q;

   // R13
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R13
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> busy);
   // R2
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_done && !xfer_err) |=>
         (xfer_req && $stable(xfer_sector) && $stable(xfer_head) && $stable(xfer_cyl)));
   // R4
   verify_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> !is_verify);
   // R4
   synd_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && syndrome == SYND_OK) |-> (err_flags == '0 && !equip_check));
   // R12
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && xfer_err) |=> (done && need_reset));
   // R8
   seek_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seek_end) |-> (cur_cyl < drive_cyls));
endmodule

// File: tb/disk_cmd_seq_test.sv
`timescale 1ns/1ps
module disk_cmd_seq_test;
   localparam int DLY = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [47:0] cmd_ccb = '0;
   logic        cmd_ready;
   logic        drive_present = 1'b1;
   logic [9:0]  drive_cyls = 10'd20;
   logic [4:0]  drive_heads = 5'd2;
   logic [7:0]  drive_spt = 8'd4;
   logic        xfer_req, xfer_write;
   logic [9:0]  xfer_cyl;
   logic [3:0]  xfer_head;
   logic [7:0]  xfer_sector;
   logic        xfer_done = 1'b0;
   logic        xfer_err = 1'b0;
   logic        busy, done, equip_check, term_err, need_reset, seek_end;
   logic [4:0]  err_flags;
   logic [7:0]  syndrome;
   logic [9:0]  cur_cyl;

   int checks = 0;
   int errors = 0;
   logic [22:0] log_q [16];
   logic        wr_q  [16];
   int log_n = 0;
   int err_at = -1;
   bit finished = 0;

   disk_cmd_seq #(.SECTOR_DELAY(DLY)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ccb(cmd_ccb),
      .cmd_ready(cmd_ready), .drive_present(drive_present),
      .drive_cyls(drive_cyls), .drive_heads(drive_heads), .drive_spt(drive_spt),
      .xfer_req(xfer_req), .xfer_write(xfer_write), .xfer_cyl(xfer_cyl),
      .xfer_head(xfer_head), .xfer_sector(xfer_sector), .xfer_done(xfer_done),
      .xfer_err(xfer_err), .busy(busy), .done(done), .err_flags(err_flags),
      .equip_check(equip_check), .term_err(term_err), .need_reset(need_reset),
      .seek_end(seek_end), .syndrome(syndrome), .cur_cyl(cur_cyl));

   always #2.5 clk = ~clk;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [47:0] mk(input logic [3:0] op, input logic park,
      input logic aseek, input logic [9:0] cyl, input logic [3:0] head,
      input logic [7:0] sec, input logic [7:0] cnt);
      return {cnt, 8'h02, sec, cyl[7:0], head, 2'b00, cyl[9:8],
              op, 1'b0, aseek, 1'b0, park};
   endfunction

   function automatic logic [22:0] chs(input logic [9:0] c, input logic [3:0] h,
                                      input logic [7:0] s);
      return {c, h, s, 1'b0};
   endfunction

   // data mover model
   initial begin
      forever begin
         @(negedge clk);
         if (xfer_done || xfer_err) begin
            xfer_done = 1'b0;
            xfer_err  = 1'b0;
         end else if (xfer_req) begin
            if (log_n < 16) begin
               log_q[log_n] = chs(xfer_cyl, xfer_head, xfer_sector);
               wr_q[log_n]  = xfer_write;
            end
            if (log_n == err_at) xfer_err = 1'b1;
            else                 xfer_done = 1'b1;
            log_n++;
         end
      end
   end

   task automatic run_cmd(input logic [47:0] ccb, output int lat);
      @(negedge clk);
      cmd_ccb   = ccb;
      cmd_valid = 1'b1;
      log_n     = 0;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      lat = 1;
      while (!done && lat < 3000) begin
         @(negedge clk);
         lat++;
      end
      check("R13", "done seen", {31'd0, done}, 32'd1);
      @(negedge clk);
      check("R13", "done one cycle", {31'd0, done}, 32'd0);
      check("R13", "busy cleared", {31'd0, busy}, 32'd0);
   endtask

   task automatic t_reset;
      check("R1", "cmd_ready", {31'd0, cmd_ready}, 32'd1);
      check("R1", "busy", {31'd0, busy}, 32'd0);
      check("R1", "done", {31'd0, done}, 32'd0);
      check("R1", "xfer_req", {31'd0, xfer_req}, 32'd0);
      check("R1", "flags", {27'd0, err_flags}, 32'd0);
      check("R1", "syndrome", {24'd0, syndrome}, 32'd0);
      check("R1", "cur_cyl", {22'd0, cur_cyl}, 32'd0);
   endtask

   task automatic t_read;
      int lat;
      run_cmd(mk(4'h1, 1'b0, 1'b1, 10'd5, 4'd1, 8'd3, 8'd4), lat);
      check("R2", "sector count", log_n, 4);
      check("R2", "s0", {9'd0, log_q[0]}, {9'd0, chs(10'd5, 4'd1, 8'd3)});
      check("R2", "s1", {9'd0, log_q[1]}, {9'd0, chs(10'd5, 4'd1, 8'd4)});
      check("R2", "s2 wrap", {9'd0, log_q[2]}, {9'd0, chs(10'd6, 4'd0, 8'd1)});
      check("R2", "s3", {9'd0, log_q[3]}, {9'd0, chs(10'd6, 4'd0, 8'd2)});
      check("R2", "direction", {31'd0, wr_q[0]}, 32'd0);
      check("R2", "syndrome", {24'd0, syndrome}, 32'hD4);
      check("R2", "flags", {27'd0, err_flags}, 32'd0);
      check("R5", "cur_cyl after", {22'd0, cur_cyl}, 32'd6);
   endtask

   task automatic t_write;
      int lat;
      run_cmd(mk(4'h9, 1'b0, 1'b0, 10'd6, 4'd0, 8'd1, 8'd2), lat);
      check("R3", "sector count", log_n, 2);
      check("R3", "s0", {9'd0, log_q[0]}, {9'd0, chs(10'd6, 4'd0, 8'd1)});
      check("R3", "s1", {9'd0, log_q[1]}, {9'd0, chs(10'd6, 4'd0, 8'd2)});
      check("R3", "direction", {31'd0, wr_q[1]}, 32'd1);
      check("R3", "syndrome", {24'd0, syndrome}, 32'hD4);
   endtask

   task automatic t_verify;
      int l1, l3;
      run_cmd(mk(4'h2, 1'b0, 1'b1, 10'd2, 4'd0, 8'd1, 8'd1), l1);
      check("R4", "no request (1)", log_n, 0);
      run_cmd(mk(4'hA, 1'b0, 1'b1, 10'd2, 4'd0, 8'd1, 8'd3), l3);
      check("R4", "no request (3)", log_n, 0);
      check("R4", "syndrome", {24'd0, syndrome}, 32'hD4);
      check("R4", "per-sector time", l3 - l1, 2 * (DLY + 2));
   endtask

   task automatic t_autoseek_bad;
      int lat;
      run_cmd(mk(4'h1, 1'b0, 1'b1, 10'd20, 4'd0, 8'd1, 8'd1), lat);
      check("R5", "cyl error", {27'd0, err_flags}, 32'h02);
      check("R5", "no transfer", log_n, 0);
      check("R5", "cur_cyl kept", {22'd0, cur_cyl}, 32'd2);
   endtask

   task automatic t_wrong_cyl;
      int lat;
      run_cmd(mk(4'h1, 1'b0, 1'b0, 10'd3, 4'd0, 8'd1, 8'd1), lat);
      check("R6", "wrong cyl", {27'd0, err_flags}, 32'h04);
      check("R6", "no transfer", log_n, 0);
   endtask

   task automatic t_bad_addr;
      int lat;
      run_cmd(mk(4'h1, 1'b0, 1'b1, 10'd6, 4'd2, 8'd1, 8'd1), lat);
      check("R7", "head error", {27'd0, err_flags}, 32'h02);
      check("R7", "no transfer head", log_n, 0);
      run_cmd(mk(4'h9, 1'b0, 1'b1, 10'd6, 4'd1, 8'd5, 8'd1), lat);
      check("R7", "mark not found", {27'd0, err_flags}, 32'h08);
      check("R7", "no transfer sector", log_n, 0);
   endtask

   task automatic t_seek;
      int lat;
      run_cmd(mk(4'hE, 1'b0, 1'b0, 10'd10, 4'd0, 8'd0, 8'd0), lat);
      check("R8", "seek cyl", {22'd0, cur_cyl}, 32'd10);
      check("R8", "seek end", {31'd0, seek_end}, 32'd1);
      run_cmd(mk(4'hE, 1'b0, 1'b0, 10'd25, 4'd0, 8'd0, 8'd0), lat);
      check("R8", "bad seek flag", {27'd0, err_flags}, 32'h02);
      check("R8", "bad seek end low", {31'd0, seek_end}, 32'd0);
      check("R8", "bad seek cyl kept", {22'd0, cur_cyl}, 32'd10);
      run_cmd(mk(4'hE, 1'b1, 1'b0, 10'd3, 4'd0, 8'd0, 8'd0), lat);
      check("R8", "park cyl", {22'd0, cur_cyl}, 32'd19);
      check("R8", "park end", {31'd0, seek_end}, 32'd1);
   endtask

   task automatic t_recal;
      int lat;
      run_cmd(mk(4'h8, 1'b0, 1'b0, 10'd7, 4'd0, 8'd0, 8'd0), lat);
      check("R9", "recal cyl", {22'd0, cur_cyl}, 32'd0);
      check("R9", "recal flags", {27'd0, err_flags}, 32'd0);
      drive_present = 1'b0;
      run_cmd(mk(4'h8, 1'b0, 1'b0, 10'd0, 4'd0, 8'd0, 8'd0), lat);
      check("R9", "absent not ready", {27'd0, err_flags}, 32'h01);
      check("R9", "absent term", {31'd0, term_err}, 32'd1);
      drive_present = 1'b1;
   endtask

   task automatic t_invalid;
      int lat;
      logic [3:0] ops [4] = '{4'h3, 4'h5, 4'hD, 4'h0};
      for (int i = 0; i < 4; i++) begin
         run_cmd(mk(ops[i], 1'b0, 1'b0, 10'd0, 4'd0, 8'd1, 8'd1), lat);
         check("R10", $sformatf("invalid op %0h", ops[i]), {27'd0, err_flags}, 32'h10);
      end
      drive_present = 1'b0;
      run_cmd(mk(4'h5, 1'b0, 1'b0, 10'd0, 4'd0, 8'd1, 8'd1), lat);
      check("R10", "absent read-id", {27'd0, err_flags}, 32'h01);
   endtask

   task automatic t_absent;
      int lat;
      run_cmd(mk(4'h1, 1'b0, 1'b1, 10'd1, 4'd0, 8'd1, 8'd2), lat);
      check("R11", "not ready", {27'd0, err_flags}, 32'h01);
      check("R11", "no transfer", log_n, 0);
      check("R11", "syndrome", {24'd0, syndrome}, 32'd0);
      drive_present = 1'b1;
   endtask

   task automatic t_xfer_err;
      int lat;
      err_at = 1;
      run_cmd(mk(4'h1, 1'b0, 1'b1, 10'd4, 4'd0, 8'd1, 8'd3), lat);
      err_at = -1;
      check("R12", "requests", log_n, 2);
      check("R12", "equip check", {31'd0, equip_check}, 32'd1);
      check("R12", "need reset", {31'd0, need_reset}, 32'd1);
      check("R12", "syndrome", {24'd0, syndrome}, 32'd0);
   endtask

   task automatic t_edge_wrap;
      int lat;
      run_cmd(mk(4'h1, 1'b0, 1'b1, 10'd19, 4'd1, 8'd4, 8'd2), lat);
      check("R14", "requests", log_n, 1);
      check("R14", "s0", {9'd0, log_q[0]}, {9'd0, chs(10'd19, 4'd1, 8'd4)});
      check("R14", "cyl error", {27'd0, err_flags}, 32'h02);
      check("R14", "syndrome", {24'd0, syndrome}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read();
      t_write();
      t_verify();
      t_autoseek_bad();
      t_seek();
      t_wrong_cyl();
      run_cmd(mk(4'hE, 1'b0, 1'b0, 10'd6, 4'd0, 8'd0, 8'd0), checks_dummy);
      t_bad_addr();
      t_recal();
      t_invalid();
      t_absent();
      t_xfer_err();
      t_edge_wrap();
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   int checks_dummy;
endmodule